// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block is the priority core of a per-processor interrupt controller. It keeps three 256-entry bit sets, indexed by an 8-bit vector number: vectors waiting for service, vectors the processor is handling now, and whether each vector was last requested as level- or edge-triggered. It also holds a 4-bit task priority class and a 9-bit spurious-vector register whose top bit enables the controller. Requests arrive one vector per cycle. The block raises `cpu_irq` while a waiting vector is allowed through by the current processor priority.

The processor takes an interrupt with a one-cycle `ack_req` pulse and reads the chosen vector one cycle later on `ack_vector`, qualified by `ack_valid`. It retires the interrupt with an `eoi` pulse. A small acknowledge machine has three states. In `ST_IDLE` it waits. The transition IDLE→GRANT is taken on `ack_req` when the top pending vector may be taken. The transition IDLE→SPUR is taken on `ack_req` otherwise. `ST_GRANT` and `ST_SPUR` each show the response for exactly one cycle and return to IDLE unconditionally (GRANT→IDLE, SPUR→IDLE). A side query port reads the three bits of any vector.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all three vector sets are empty, the task priority reads 0, the spurious register reads 0x0FF (disabled), and `cpu_irq` and `ack_valid` are low.
- R2: A request sets the pending bit of `req_vector`. It writes that vector's level bit to `req_level`, so 1 means level-triggered and 0 means edge-triggered, and a later request of the same vector overwrites it.
- R3: `cpu_irq` is high exactly when spurious bit 8 is set, some vector is pending, and it is not the case that the processor priority class is nonzero and the top pending vector's class (bits [7:4]) is less than or equal to it.
- R4: The processor priority class equals the task priority when that is greater than or equal to the class of the highest in-service vector. Otherwise it equals that in-service class, which is 0 when nothing is in service.
- R5: An acknowledge with a nonzero task priority T, where the top pending vector is less than or equal to T×16, returns spurious bits [7:0] and changes no set.
- R6: Any other acknowledge with the controller enabled and a vector pending clears the top pending bit, sets the same in-service bit, and returns that vector. The response appears on `ack_vector` with `ack_valid` high in the cycle after `ack_req`.
- R7: "Top" in any set means the highest-numbered set bit.
- R8: `eoi` clears the highest in-service bit. With no vector in service it changes nothing.
- R9: A task priority write stores the 4-bit value, which reads back unchanged.
- R10: A spurious write stores all 9 bits, which read back unchanged.
- R11: An acknowledge while disabled (bit 8 clear) or with nothing pending returns spurious bits [7:0] and changes no set.
- R12: `ack_valid` stays high for exactly one cycle. An `ack_req` seen while a response is shown is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| ack_req | input | 1 | Acknowledge strobe |
| ack_valid | output | 1 | Response valid (one cycle) |
| ack_vector | output | 8 | Granted or spurious vector |
| eoi | input | 1 | End-of-interrupt strobe |
| task_pri_we | input | 1 | Task priority write enable |
| task_pri_wdata | input | 4 | Task priority class to write |
| task_pri_rdata | output | 4 | Current task priority class |
| spur_we | input | 1 | Spurious register write enable |
| spur_wdata | input | 9 | Bit 8 enable, bits [7:0] spurious vector |
| spur_rdata | output | 9 | Current spurious register |
| cpu_irq | output | 1 | Interrupt line to the processor |
| qry_vector | input | 8 | Vector to inspect |
| qry_pending | output | 1 | Pending bit of `qry_vector` |
| qry_inservice | output | 1 | In-service bit of `qry_vector` |
| qry_level | output | 1 | Level bit of `qry_vector` |

## Verification
Directed patterns set the task priority and the in-service class against each other. Pending vectors are placed just above and exactly at the blocking boundary. This separates a class comparison from a full-vector comparison, and it separates the task priority from the in-service class as the source of the processor priority. Several vectors in the same 32-bit word and in different words show whether the highest bit wins, or merely the first one found. A long constrained-random mix of requests, acknowledges, end-of-interrupts and register writes is checked against a bench model after every step. It covers interleavings that the directed cases do not, such as overwriting a vector's level bit and retiring vectors out of arrival order.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GRANT = 2'd1,
        ST_SPUR  = 2'd2
    } ack_state_e;

    localparam int CLS_W = 4;

endpackage

// File: rtl/vec_prio_find.sv
// Reports the highest-numbered set bit of a wide vector, searched word by word.
module vec_prio_find #(
    parameter int NUM_BITS = 256,
    parameter int WORD_W   = 32,
    parameter int IDX_W    = $clog2(NUM_BITS)
) (
    input  logic [NUM_BITS-1:0] bits,
    output logic                found,
    output logic [IDX_W-1:0]    idx
);
    localparam int NUM_WORDS = NUM_BITS / WORD_W;
    localparam int BIT_W     = $clog2(WORD_W);

    logic [NUM_WORDS-1:0] word_hit;
    logic [BIT_W-1:0]     word_idx [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic             hit_l;
        logic [BIT_W-1:0] idx_l;
        always_comb begin
            hit_l = 1'b0;
            idx_l = '0;
            for (int b = 0; b < WORD_W; b++) begin
                if (bits[w*WORD_W + b]) begin
                    hit_l = 1'b1;
                    idx_l = BIT_W'(b);
                end
            end
        end
        assign word_hit[w] = hit_l;
        assign word_idx[w] = idx_l;
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (word_hit[w]) begin
                found = 1'b1;
                idx   = IDX_W'(w * WORD_W + int'(word_idx[w]));
            end
        end
    end
endmodule

// File: rtl/irq_ack_fsm.sv
// Acknowledge handshake: one response cycle per accepted request.
module irq_ack_fsm
    import irq_prio_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_req,
    input  logic             grant_ok,
    input  logic [VEC_W-1:0] grant_vec,
    input  logic [VEC_W-1:0] spur_vec,
    output logic             grant_stb,
    output logic             ack_valid,
    output logic [VEC_W-1:0] ack_vector
);
    ack_state_e       state_q, state_d;
    logic [VEC_W-1:0] vec_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (ack_req) state_d = grant_ok ? ST_GRANT : ST_SPUR;
            ST_GRANT: state_d = ST_IDLE;
            ST_SPUR:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && ack_req)
                vec_q <= grant_ok ? grant_vec : spur_vec;
        end
    end

    always_comb begin
        grant_stb = 1'b0;
        ack_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  grant_stb = ack_req && grant_ok;
            ST_GRANT: ack_valid = 1'b1;
            ST_SPUR:  ack_valid = 1'b1;
            default:  ;
        endcase
    end

    assign ack_vector = vec_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32,
    parameter int VEC_W   = $clog2(NUM_VEC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vector,
    input  logic             req_level,
    input  logic             ack_req,
    output logic             ack_valid,
    output logic [VEC_W-1:0] ack_vector,
    input  logic             eoi,
    input  logic             task_pri_we,
    input  logic [CLS_W-1:0] task_pri_wdata,
    output logic [CLS_W-1:0] task_pri_rdata,
    input  logic             spur_we,
    input  logic [VEC_W:0]   spur_wdata,
    output logic [VEC_W:0]   spur_rdata,
    output logic             cpu_irq,
    input  logic [VEC_W-1:0] qry_vector,
    output logic             qry_pending,
    output logic             qry_inservice,
    output logic             qry_level
);
    localparam int SUB_W = VEC_W - CLS_W;

    logic [NUM_VEC-1:0] pend_q, insvc_q, lvl_q;
    logic [CLS_W-1:0]   tpri_q;
    logic [VEC_W:0]     spur_q;

    logic             pend_any, isr_any;
    logic [VEC_W-1:0] pend_top, isr_top;
    logic [CLS_W-1:0] isr_cls, ppr_cls, pend_cls;
    logic             enabled, grant_ok, grant_stb;

    vec_prio_find #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W), .IDX_W(VEC_W)) u_pend_find (
        .bits(pend_q), .found(pend_any), .idx(pend_top)
    );
    vec_prio_find #(.NUM_BITS(NUM_VEC), .WORD_W(WORD_W), .IDX_W(VEC_W)) u_isr_find (
        .bits(insvc_q), .found(isr_any), .idx(isr_top)
    );

    assign enabled  = spur_q[VEC_W];
    assign pend_cls = pend_top[VEC_W-1 -: CLS_W];
    assign isr_cls  = isr_any ? isr_top[VEC_W-1 -: CLS_W] : '0;
    assign ppr_cls  = (tpri_q >= isr_cls) ? tpri_q : isr_cls;
    assign cpu_irq  = enabled && pend_any && !((ppr_cls != '0) && (pend_cls <= ppr_cls));
    assign grant_ok = enabled && pend_any &&
                      !((tpri_q != '0) && (pend_top <= {tpri_q, {SUB_W{1'b0}}}));

    irq_ack_fsm #(.VEC_W(VEC_W)) u_ack (
        .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .grant_ok(grant_ok),
        .grant_vec(pend_top), .spur_vec(spur_q[VEC_W-1:0]),
        .grant_stb(grant_stb), .ack_valid(ack_valid), .ack_vector(ack_vector)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= '0;
            insvc_q <= '0;
            lvl_q   <= '0;
            tpri_q  <= '0;
            spur_q  <= {1'b0, {VEC_W{1'b1}}};
        end else begin
            if (grant_stb) pend_q[pend_top] <= 1'b0;
            if (req_valid) begin
                pend_q[req_vector] <= 1'b1;
                lvl_q[req_vector]  <= req_level;
            end
            if (eoi && isr_any) insvc_q[isr_top] <= 1'b0;
            if (grant_stb)      insvc_q[pend_top] <= 1'b1;
            if (task_pri_we) tpri_q <= task_pri_wdata;
            if (spur_we)     spur_q <= spur_wdata;
        end
    end

    assign task_pri_rdata = tpri_q;
    assign spur_rdata     = spur_q;
    assign qry_pending    = pend_q[qry_vector];
    assign qry_inservice  = insvc_q[qry_vector];
    assign qry_level      = lvl_q[qry_vector];
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
    parameter int NUM_VEC = 256,
    parameter int VEC_W   = $clog2(NUM_VEC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ack_valid,
    input logic [VEC_W-1:0]   ack_vector,
    input logic               cpu_irq,
    input logic [VEC_W:0]     spur_rdata,
    input logic               spur_we,
    input logic [VEC_W:0]     spur_wdata,
    input logic               task_pri_we,
    input logic [3:0]         task_pri_wdata,
    input logic [3:0]         task_pri_rdata,
    input logic [NUM_VEC-1:0] pend_q,
    input logic [NUM_VEC-1:0] insvc_q,
    input logic               grant_stb,
    input logic [VEC_W-1:0]   pend_top,
    input logic               isr_any,
    input logic [VEC_W-1:0]   isr_top,
    input logic               req_valid,
    input logic [VEC_W-1:0]   req_vector,
    input logic               eoi
);
    assert_resp_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid);

    assert_irq_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> (spur_rdata[VEC_W] && (|pend_q)));

    assert_tpri_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        task_pri_we |=> task_pri_rdata == $past(task_pri_wdata));

    assert_spur_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        spur_we |=> spur_rdata == $past(spur_wdata));

    assert_grant_move_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_stb && !(req_valid && req_vector == pend_top))
        |=> (insvc_q[$past(pend_top)] && !pend_q[$past(pend_top)]));

    assert_grant_resp_R6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_stb |=> (ack_valid && ack_vector == $past(pend_top)));

    assert_eoi_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && isr_any && !(grant_stb && pend_top == isr_top))
        |=> !insvc_q[$past(isr_top)]);
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_vector(ack_vector),
    .cpu_irq(cpu_irq), .spur_rdata(spur_rdata), .spur_we(spur_we),
    .spur_wdata(spur_wdata), .task_pri_we(task_pri_we),
    .task_pri_wdata(task_pri_wdata), .task_pri_rdata(task_pri_rdata),
    .pend_q(pend_q), .insvc_q(insvc_q), .grant_stb(grant_stb),
    .pend_top(pend_top), .isr_any(isr_any), .isr_top(isr_top),
    .req_valid(req_valid), .req_vector(req_vector), .eoi(eoi)
);

// File: tb/test_irq_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_prio_ctrl;
    localparam int NV = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_level = 1'b0, ack_req = 1'b0, eoi = 1'b0;
    logic [7:0] req_vector = '0, qry_vector = '0;
    logic task_pri_we = 1'b0, spur_we = 1'b0;
    logic [3:0] task_pri_wdata = '0;
    logic [8:0] spur_wdata = '0;
    logic ack_valid, cpu_irq, qry_pending, qry_inservice, qry_level;
    logic [7:0] ack_vector;
    logic [3:0] task_pri_rdata;
    logic [8:0] spur_rdata;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    bit [NV-1:0] m_pend = '0, m_isr = '0, m_lvl = '0;
    logic [3:0] m_tpri = '0;
    logic [8:0] m_spur = 9'h0FF;

    always #4 clk = ~clk;

    irq_prio_ctrl i_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .req_level(req_level), .ack_req(ack_req), .ack_valid(ack_valid),
        .ack_vector(ack_vector), .eoi(eoi), .task_pri_we(task_pri_we),
        .task_pri_wdata(task_pri_wdata), .task_pri_rdata(task_pri_rdata),
        .spur_we(spur_we), .spur_wdata(spur_wdata), .spur_rdata(spur_rdata),
        .cpu_irq(cpu_irq), .qry_vector(qry_vector), .qry_pending(qry_pending),
        .qry_inservice(qry_inservice), .qry_level(qry_level)
    );

    function automatic int top_of(bit [NV-1:0] v);
        for (int i = NV-1; i >= 0; i--) if (v[i]) return i;
        return -1;
    endfunction

    function automatic bit exp_irq();
        int p; int s; int icls; int pcls;
        p = top_of(m_pend);
        s = top_of(m_isr);
        if (!m_spur[8] || p < 0) return 1'b0;
        icls = (s < 0) ? 0 : (s >> 4);
        pcls = (int'(m_tpri) >= icls) ? int'(m_tpri) : icls;
        if (pcls != 0 && (p >> 4) <= pcls) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input string r, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic check_irq(input string r);
        chk(r, int'(cpu_irq), int'(exp_irq()));
    endtask

    task automatic check_vec(input int v, input string r);
        qry_vector = 8'(v);
        #1;
        chk({r, " pending"},   int'(qry_pending),   int'(m_pend[v]));
        chk({r, " inservice"}, int'(qry_inservice), int'(m_isr[v]));
        chk({r, " level"},     int'(qry_level),     int'(m_lvl[v]));
    endtask

    task automatic do_req(input int v, input bit lvl);
        req_valid = 1'b1; req_vector = 8'(v); req_level = lvl;
        cyc();
        req_valid = 1'b0;
        m_pend[v] = 1'b1; m_lvl[v] = lvl;
    endtask

    task automatic do_ack();
        int p; int exp; string r;
        p = top_of(m_pend);
        if (!m_spur[8] || p < 0) begin
            exp = int'(m_spur[7:0]); r = "R11 spurious";
        end else if (m_tpri != 0 && p <= int'(m_tpri) * 16) begin
            exp = int'(m_spur[7:0]); r = "R5 blocked";
        end else begin
            exp = p; r = "R6 grant"; m_pend[p] = 1'b0; m_isr[p] = 1'b1;
        end
        ack_req = 1'b1;
        cyc();
        ack_req = 1'b0;
        chk({r, " valid"}, int'(ack_valid), 1);
        chk({r, " vector"}, int'(ack_vector), exp);
        cyc();
        chk("R12 valid drop", int'(ack_valid), 0);
    endtask

    task automatic do_eoi();
        int s;
        s = top_of(m_isr);
        if (s >= 0) m_isr[s] = 1'b0;
        eoi = 1'b1;
        cyc();
        eoi = 1'b0;
    endtask

    task automatic do_tpri(input int t);
        task_pri_we = 1'b1; task_pri_wdata = 4'(t);
        cyc();
        task_pri_we = 1'b0; m_tpri = 4'(t);
        chk("R9 readback", int'(task_pri_rdata), t);
    endtask

    task automatic do_spur(input int s);
        spur_we = 1'b1; spur_wdata = 9'(s);
        cyc();
        spur_we = 1'b0; m_spur = 9'(s);
        chk("R10 readback", int'(spur_rdata), s);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        chk("R1 irq", int'(cpu_irq), 0);
        chk("R1 ack_valid", int'(ack_valid), 0);
        chk("R1 spurious", int'(spur_rdata), 'h0FF);
        chk("R1 task pri", int'(task_pri_rdata), 0);
        check_vec(0, "R1"); check_vec(255, "R1");

        // R3 / R11: disabled controller
        do_req('h40, 1'b0);
        chk("R3 disabled irq", int'(cpu_irq), 0);
        do_ack();
        check_vec('h40, "R11 untouched");

        do_spur('h12F);
        chk("R3 enabled irq", int'(cpu_irq), 1);

        // R2 level bits and overwrite; R7 highest wins inside a word
        do_req('h41, 1'b1);
        do_req('h20, 1'b0);
        check_vec('h41, "R2 level");
        check_vec('h20, "R2 edge");
        do_req('h41, 1'b0);
        check_vec('h41, "R2 overwrite");
        do_ack();
        chk("R7 top vector", int'(ack_vector), 'h41);
        check_vec('h41, "R6 moved");
        // in-service class 4 blocks pending 0x40 (R4)
        chk("R4 isr blocks", int'(cpu_irq), 0);
        check_irq("R4");

        // R5: task priority 5 blocks 0x40
        do_tpri(5);
        check_irq("R3");
        do_ack();
        check_vec('h40, "R5 unchanged");

        // R4: task priority below in-service class
        do_tpri(2);
        do_req('h50, 1'b0);
        chk("R4 above isr class", int'(cpu_irq), 1);
        do_ack();
        chk("R6 vector 0x50", int'(ack_vector), 'h50);

        // R8: retire in order, then with nothing in service
        do_eoi(); check_vec('h50, "R8 retire top");
        check_vec('h41, "R8 keep lower");
        do_eoi(); check_vec('h41, "R8 retire next");
        do_eoi(); check_irq("R8 empty");

        // R5 boundary: task pri 3, pending 0x30 blocked, 0x35 granted
        do_ack(); do_ack(); do_ack();
        do_eoi(); do_eoi(); do_eoi(); do_eoi();
        do_tpri(3);
        do_req('h30, 1'b0);
        chk("R3 class equal", int'(cpu_irq), 0);
        do_ack();
        chk("R5 equal spurious", int'(ack_vector), 'h2F);
        do_req('h35, 1'b1);
        chk("R3 class equal 0x35", int'(cpu_irq), 0);
        do_ack();
        chk("R5 above boundary", int'(ack_vector), 'h35);
        do_eoi();

        // R12: held acknowledge, second cycle ignored
        do_tpri(0);
        do_req('hA0, 1'b0);
        ack_req = 1'b1;
        cyc();
        chk("R12 first vector", int'(ack_vector), 'hA0);
        m_pend['hA0] = 1'b0; m_isr['hA0] = 1'b1;
        cyc();
        ack_req = 1'b0;
        chk("R12 single cycle", int'(ack_valid), 0);
        check_vec('h30, "R12 ignored");

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0, 1, 2, 3: do_req($urandom_range(0, 255), 1'($urandom_range(0, 1)));
                4, 5:       do_ack();
                6:          do_eoi();
                7:          do_tpri($urandom_range(0, 7));
                8:          do_spur({1'($urandom_range(0, 7) != 0), 8'($urandom_range(0, 255))});
                default:    check_vec($urandom_range(0, 255), "R2 random");
            endcase
            check_irq("R3 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule